// File: doc/BRIEF.md
# Test Access Port Controller with User Scan Hooks

This block is a serial test port controller in the IEEE 1149.1 style. A sixteen-state controller is stepped by TMS on each rising TCK edge. It owns a three-bit instruction path and a one-bit pass-through data register. Two further data registers live outside the block in user logic. For each of those the block decodes a select, takes back a scan-out bit, and supplies a gated data-register clock. The boundary register also lives outside the block; only its serial output enters here.

The serial output is chosen from the instruction shift path, the pass-through bit, the boundary scan-out or one of the user scan-outs. It is updated on the falling TCK edge and is enabled only in the two shifting states. An idle strobe equal to the NAND of TCK and the Run-Test/Idle indication lets user logic run its own self-test while the port rests.

Top module: `tap_ctrl_user`

## Requirements
- R1: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. Entering that state loads the instruction code 111, so both user selects go low.
- R2: While trst_n is low, the controller is held in Test-Logic-Reset with instruction 111. In that condition tdo_en, usr1_sel, usr2_sel and dr_clk are all 0 and idle_n is 1.
- R3: With instruction 111 loaded, the data path is a single flip-flop. It captures 0 in Capture-DR, and in Shift-DR tdo gives each tdi bit one TCK later.
- R4: In Capture-IR the instruction shift path loads 001, whatever instruction is active. Shifting out least significant bit first therefore gives the sequence 1, 0, 0.
- R5: A new instruction takes effect at the rising edge that leaves Update-IR. usr1_sel is 1 exactly while code 010 is loaded and usr2_sel exactly while code 011 is loaded. The two are never high together.
- R6: In Shift-DR, tdo carries usr1_tdo while code 010 is loaded and usr2_tdo while code 011 is loaded.
- R7: In Shift-DR, tdo carries bsr_tdo while code 000 or code 001 is loaded.
- R8: The codes 100, 101 and 110 act as 111: neither select is raised, and the data path is the single pass-through flip-flop.
- R9: tdo_en is 1 only while the controller is in Shift-IR or Shift-DR. tdo and tdo_en change only on falling TCK edges.
- R10: dr_clk follows TCK high phases only in Capture-DR and Shift-DR while a user instruction is loaded. Shifting n bits gives n+1 pulses; any other instruction gives none.
- R11: idle_n is low only during a TCK high phase while the controller is in Run-Test/Idle, and is high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| usr1_tdo | input | 1 | Serial output of user register 1 |
| usr2_tdo | input | 1 | Serial output of user register 2 |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Drive enable for tdo; low means high-impedance |
| usr1_sel | output | 1 | User instruction 1 is loaded |
| usr2_sel | output | 1 | User instruction 2 is loaded |
| dr_clk | output | 1 | Gated data-register clock for user registers |
| idle_n | output | 1 | NAND of TCK and the Run-Test/Idle indication |

## Verification
A wrong controller state shows within one TCK cycle in tdo_en, idle_n or the dr_clk pulse count, since each of them is derived from the current state. A wrong instruction shows at the first data shift as wrong tdo bits: a stuck or swapped mux gives a constant or foreign stream, and a lost pass-through stage makes the leading 0 disappear. A fault in the reset path shows as a select that stays high after five TMS-high edges.

// File: rtl/tap_pkg.sv
package tap_pkg;
   typedef enum logic [3:0] {
      ST_TLR      = 4'h0,
      ST_RTI      = 4'h1,
      ST_SEL_DR   = 4'h2,
      ST_CAP_DR   = 4'h3,
      ST_SHIFT_DR = 4'h4,
      ST_EX1_DR   = 4'h5,
      ST_PAUSE_DR = 4'h6,
      ST_EX2_DR   = 4'h7,
      ST_UPD_DR   = 4'h8,
      ST_SEL_IR   = 4'h9,
      ST_CAP_IR   = 4'hA,
      ST_SHIFT_IR = 4'hB,
      ST_EX1_IR   = 4'hC,
      ST_PAUSE_IR = 4'hD,
      ST_EX2_IR   = 4'hE,
      ST_UPD_IR   = 4'hF
   } tap_state_t;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state_q,
   output tap_state_t state_d
);
   always_comb begin
      unique case (state_q)
         ST_TLR:      state_d = tms ? ST_TLR    : ST_RTI;
         ST_RTI:      state_d = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR:   state_d = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR:   state_d = tms ? ST_EX1_DR : ST_SHIFT_DR;
         ST_SHIFT_DR: state_d = tms ? ST_EX1_DR : ST_SHIFT_DR;
         ST_EX1_DR:   state_d = tms ? ST_UPD_DR : ST_PAUSE_DR;
         ST_PAUSE_DR: state_d = tms ? ST_EX2_DR : ST_PAUSE_DR;
         ST_EX2_DR:   state_d = tms ? ST_UPD_DR : ST_SHIFT_DR;
         ST_UPD_DR:   state_d = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR:   state_d = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR:   state_d = tms ? ST_EX1_IR : ST_SHIFT_IR;
         ST_SHIFT_IR: state_d = tms ? ST_EX1_IR : ST_SHIFT_IR;
         ST_EX1_IR:   state_d = tms ? ST_UPD_IR : ST_PAUSE_IR;
         ST_PAUSE_IR: state_d = tms ? ST_EX2_IR : ST_PAUSE_IR;
         ST_EX2_IR:   state_d = tms ? ST_UPD_IR : ST_SHIFT_IR;
         ST_UPD_IR:   state_d = tms ? ST_SEL_DR : ST_RTI;
         default:     state_d = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state_q <= ST_TLR;
      else         state_q <= state_d;
   end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int IR_W       = 3,
   parameter int CAP_VALUE  = 1,
   parameter int RESET_CODE = 7
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_state_t      state_q,
   input  tap_state_t      state_d,
   output logic            sr_lsb,
   output logic [IR_W-1:0] ir_q
);
   localparam logic [IR_W-1:0] K_CAP = IR_W'(CAP_VALUE);
   localparam logic [IR_W-1:0] K_RST = IR_W'(RESET_CODE);

   logic [IR_W-1:0] sr_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr_q <= K_CAP;
      end else if (state_q == ST_CAP_IR) begin
         sr_q <= K_CAP;
      end else if (state_q == ST_SHIFT_IR) begin
         if (IR_W == 1) sr_q <= tdi;
         else           sr_q <= {tdi, sr_q[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 ir_q <= K_RST;
      else if (state_d == ST_TLR)  ir_q <= K_RST;
      else if (state_q == ST_UPD_IR) ir_q <= sr_q;
   end

   assign sr_lsb = sr_q[0];
endmodule

// File: rtl/tap_bypass.sv
module tap_bypass
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tdi,
   input  tap_state_t state_q,
   output logic       bit_q
);
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                     bit_q <= 1'b0;
      else if (state_q == ST_CAP_DR)   bit_q <= 1'b0;
      else if (state_q == ST_SHIFT_DR) bit_q <= tdi;
   end
endmodule

// File: rtl/tap_ctrl_user.sv
module tap_ctrl_user
   import tap_pkg::*;
#(
   parameter int IR_W        = 3,
   parameter int CODE_EXTEST = 0,
   parameter int CODE_SAMPLE = 1,
   parameter int CODE_USER1  = 2,
   parameter int CODE_USER2  = 3,
   parameter int CODE_BYPASS = 7,
   parameter int IR_CAPTURE  = 1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   input  logic bsr_tdo,
   input  logic usr1_tdo,
   input  logic usr2_tdo,
   output logic tdo,
   output logic tdo_en,
   output logic usr1_sel,
   output logic usr2_sel,
   output logic dr_clk,
   output logic idle_n
);
   localparam int N_USER = 2;
   localparam int MAX_CODE = (1 << IR_W) - 1;
   localparam int USER_CODE [N_USER] = '{CODE_USER1, CODE_USER2};
   localparam logic [IR_W-1:0] K_EXT = IR_W'(CODE_EXTEST);
   localparam logic [IR_W-1:0] K_SMP = IR_W'(CODE_SAMPLE);

   if (IR_W < 2) begin : g_bad_width
      $error("tap_ctrl_user: IR_W must be at least 2");
   end
   if (CODE_EXTEST > MAX_CODE || CODE_SAMPLE > MAX_CODE || CODE_USER1 > MAX_CODE ||
       CODE_USER2 > MAX_CODE || CODE_BYPASS > MAX_CODE || IR_CAPTURE > MAX_CODE) begin : g_bad_code
      $error("tap_ctrl_user: an instruction code does not fit IR_W");
   end
   if (CODE_USER1 == CODE_USER2 || CODE_USER1 == CODE_BYPASS || CODE_USER2 == CODE_BYPASS ||
       CODE_USER1 == CODE_EXTEST || CODE_USER2 == CODE_EXTEST ||
       CODE_USER1 == CODE_SAMPLE || CODE_USER2 == CODE_SAMPLE) begin : g_dup_code
      $error("tap_ctrl_user: user instruction codes must be unique");
   end

   tap_state_t state_q;
   tap_state_t state_d;
   logic [IR_W-1:0] ir_q;
   logic ir_lsb;
   logic byp_q;

   tap_fsm u_fsm (
      .tck     (tck),
      .trst_n  (trst_n),
      .tms     (tms),
      .state_q (state_q),
      .state_d (state_d)
   );

   tap_ir #(
      .IR_W       (IR_W),
      .CAP_VALUE  (IR_CAPTURE),
      .RESET_CODE (CODE_BYPASS)
   ) u_ir (
      .tck     (tck),
      .trst_n  (trst_n),
      .tdi     (tdi),
      .state_q (state_q),
      .state_d (state_d),
      .sr_lsb  (ir_lsb),
      .ir_q    (ir_q)
   );

   tap_bypass u_byp (
      .tck     (tck),
      .trst_n  (trst_n),
      .tdi     (tdi),
      .state_q (state_q),
      .bit_q   (byp_q)
   );

   // decode of the user instruction slots
   logic [N_USER-1:0] usel;
   logic [N_USER-1:0] uscan;
   assign uscan = {usr2_tdo, usr1_tdo};

   for (genvar g = 0; g < N_USER; g++) begin : g_user
      assign usel[g] = (ir_q == IR_W'(USER_CODE[g]));
   end

   logic bsr_active;
   assign bsr_active = (ir_q == K_EXT) || (ir_q == K_SMP);

   logic dr_bit;
   always_comb begin
      if (usel[0])         dr_bit = uscan[0];
      else if (usel[1])    dr_bit = uscan[1];
      else if (bsr_active) dr_bit = bsr_tdo;
      else                 dr_bit = byp_q;
   end

   logic in_shift;
   logic tdo_next;
   assign in_shift = (state_q == ST_SHIFT_IR) || (state_q == ST_SHIFT_DR);
   assign tdo_next = (state_q == ST_SHIFT_IR) ? ir_lsb : dr_bit;

   // falling-edge stage: serial output, its enable, and clock/idle gates
   logic tdo_q, tdo_en_q, dr_en_q, rti_q;

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q    <= 1'b0;
         tdo_en_q <= 1'b0;
         dr_en_q  <= 1'b0;
         rti_q    <= 1'b0;
      end else begin
         tdo_q    <= in_shift ? tdo_next : tdo_q;
         tdo_en_q <= in_shift;
         dr_en_q  <= (|usel) && ((state_q == ST_CAP_DR) || (state_q == ST_SHIFT_DR));
         rti_q    <= (state_q == ST_RTI);
      end
   end

   assign tdo      = tdo_q;
   assign tdo_en   = tdo_en_q;
   assign usr1_sel = usel[0];
   assign usr2_sel = usel[1];
   assign dr_clk   = tck & dr_en_q;
   assign idle_n   = ~(tck & rti_q);
endmodule

// File: rtl/tap_ctrl_user_chk.sv
module tap_ctrl_user_chk
   import tap_pkg::*;
(
   input logic       tck,
   input logic       trst_n,
   input logic       tms,
   input tap_state_t state,
   input logic       tdo_en,
   input logic       usr1_sel,
   input logic       usr2_sel,
   input logic       dr_clk,
   input logic       idle_n
);
   logic [2:0] tms_run;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)           tms_run <= 3'd0;
      else if (!tms)         tms_run <= 3'd0;
      else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
   end

   assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
      (tms_run == 3'd5) |-> (state == ST_TLR));

   assert_sel_exclusive_R5: assert property (@(posedge tck) disable iff (!trst_n)
      !(usr1_sel && usr2_sel));

   assert_sel_change_R5: assert property (@(posedge tck) disable iff (!trst_n)
      ((usr1_sel != $past(usr1_sel)) || (usr2_sel != $past(usr2_sel)))
      |-> ((state == ST_TLR) || ($past(state) == ST_UPD_IR)));

   assert_oe_shift_R9: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en == ((state == ST_SHIFT_IR) || (state == ST_SHIFT_DR)));

   assert_drclk_gate_R10: assert property (@(negedge tck) disable iff (!trst_n)
      dr_clk |-> (((($past(state) == ST_CAP_DR) || ($past(state) == ST_SHIFT_DR)))
                  && (usr1_sel || usr2_sel)));

   assert_idle_low_phase_R11: assert property (@(posedge tck) disable iff (!trst_n)
      idle_n);
endmodule

bind tap_ctrl_user tap_ctrl_user_chk u_chk (
   .tck      (tck),
   .trst_n   (trst_n),
   .tms      (tms),
   .state    (state_q),
   .tdo_en   (tdo_en),
   .usr1_sel (usr1_sel),
   .usr2_sel (usr2_sel),
   .dr_clk   (dr_clk),
   .idle_n   (idle_n)
);

// File: tb/tap_ctrl_user_test.sv
module tap_ctrl_user_test;
   localparam int TCK_PERIOD = 20;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1, tdi = 1'b0;
   logic bsr_tdo = 1'b0, usr1_tdo = 1'b0, usr2_tdo = 1'b0;
   logic tdo, tdo_en, usr1_sel, usr2_sel, dr_clk, idle_n;

   int n_chk = 0;
   int n_fail = 0;
   int drclk_cnt = 0;
   bit done = 0;

   tap_ctrl_user uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .bsr_tdo(bsr_tdo), .usr1_tdo(usr1_tdo), .usr2_tdo(usr2_tdo),
      .tdo(tdo), .tdo_en(tdo_en), .usr1_sel(usr1_sel), .usr2_sel(usr2_sel),
      .dr_clk(dr_clk), .idle_n(idle_n)
   );

   always #(TCK_PERIOD/2) tck = ~tck;
   always @(posedge dr_clk) drclk_cnt++;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic tms_v, input logic tdi_v);
      @(negedge tck); #2;
      tms = tms_v;
      tdi = tdi_v;
   endtask

   // from RTI: scan n bits through DR, return to RTI
   task automatic scan_dr(input int n, input logic [15:0] din,
                          output logic [15:0] dout, output int bad);
      dout = '0;
      bad = 0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         @(negedge tck); #2;
         dout[i] = tdo;
         if (!tdo_en) bad++;
         tms = (i == n-1);
         tdi = din[i];
         @(posedge tck); #2;
         if (tdo !== dout[i]) bad++;
      end
      step(1, 0); step(0, 0);
   endtask

   // from RTI: load an instruction, return captured bits, end toward RTI
   task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge tck); #2;
         cap[i] = tdo;
         tms = (i == 2);
         tdi = code[i];
      end
      step(1, 0); step(0, 0);
      @(negedge tck); #2;
   endtask

   function automatic logic [15:0] bypass_exp(input int n, input logic [15:0] din);
      logic [15:0] e = '0;
      for (int i = 1; i < n; i++) e[i] = din[i-1];
      return e;
   endfunction

   task automatic test_reset();
      logic [15:0] d;
      int bad;
      repeat (3) @(negedge tck);
      @(posedge tck); #2;
      check("R2 tdo_en in reset", tdo_en, 0);
      check("R2 selects in reset", {usr1_sel, usr2_sel}, 0);
      check("R2 dr_clk in reset", dr_clk, 0);
      check("R2 idle_n in reset", idle_n, 1);
      @(negedge tck); #2;
      trst_n = 1'b1;
      step(0, 0);
      usr1_tdo = 1; usr2_tdo = 1; bsr_tdo = 1;
      scan_dr(4, 16'h000D, d, bad);
      check("R2 bypass after reset", d, bypass_exp(4, 16'h000D));
   endtask

   task automatic test_ir_capture();
      logic [2:0] c;
      load_ir(3'b010, c);
      check("R4 capture after reset", c, 3'b001);
      load_ir(3'b111, c);
      check("R4 capture with user code active", c, 3'b001);
   endtask

   task automatic test_bypass();
      logic [15:0] d;
      int bad;
      logic [2:0] c;
      load_ir(3'b111, c);
      usr1_tdo = 1; usr2_tdo = 1; bsr_tdo = 1;
      drclk_cnt = 0;
      scan_dr(8, 16'h00B6, d, bad);
      check("R3 one-bit delay", d, bypass_exp(8, 16'h00B6));
      check("R9 enable and falling-edge stability", bad, 0);
      check("R10 no dr_clk for bypass", drclk_cnt, 0);
      @(negedge tck); #2;
      check("R9 tdo_en low outside shift", tdo_en, 0);
   endtask

   task automatic test_user();
      logic [15:0] d;
      int bad;
      logic [2:0] c;
      load_ir(3'b010, c);
      check("R5 user1 select", {usr1_sel, usr2_sel}, 2'b10);
      usr1_tdo = 1; usr2_tdo = 0; bsr_tdo = 0;
      drclk_cnt = 0;
      scan_dr(5, 16'h0000, d, bad);
      check("R6 user1 scan-out on tdo", d, 16'h001F);
      check("R10 user1 dr_clk pulses", drclk_cnt, 6);
      load_ir(3'b011, c);
      check("R5 user2 select", {usr1_sel, usr2_sel}, 2'b01);
      usr1_tdo = 0; usr2_tdo = 1; bsr_tdo = 0;
      drclk_cnt = 0;
      scan_dr(3, 16'h0000, d, bad);
      check("R6 user2 scan-out on tdo", d, 16'h0007);
      check("R10 user2 dr_clk pulses", drclk_cnt, 4);
   endtask

   task automatic test_boundary();
      logic [15:0] d;
      int bad;
      logic [2:0] c;
      usr1_tdo = 0; usr2_tdo = 0; bsr_tdo = 1;
      load_ir(3'b000, c);
      drclk_cnt = 0;
      scan_dr(4, 16'h0000, d, bad);
      check("R7 extest boundary path", d, 16'h000F);
      check("R10 no dr_clk for extest", drclk_cnt, 0);
      load_ir(3'b001, c);
      check("R7 sample selects", {usr1_sel, usr2_sel}, 0);
      scan_dr(4, 16'h0000, d, bad);
      check("R7 sample boundary path", d, 16'h000F);
   endtask

   task automatic test_unused();
      logic [15:0] d;
      int bad;
      logic [2:0] c;
      usr1_tdo = 1; usr2_tdo = 1; bsr_tdo = 1;
      load_ir(3'b101, c);
      check("R8 unused code selects", {usr1_sel, usr2_sel}, 0);
      scan_dr(6, 16'h0029, d, bad);
      check("R8 unused code acts as bypass", d, bypass_exp(6, 16'h0029));
   endtask

   task automatic test_idle();
      // tms held low: controller rests in RTI
      @(negedge tck); #2;
      check("R11 idle_n high in low phase", idle_n, 1);
      @(posedge tck); #2;
      check("R11 idle_n low in RTI high phase", idle_n, 0);
      step(1, 0);
      @(posedge tck); #2;
      @(negedge tck); #2;
      @(posedge tck); #2;
      check("R11 idle_n high outside RTI", idle_n, 1);
      step(1, 0); step(0, 0);
      @(negedge tck); #2;
   endtask

   task automatic test_tms_reset();
      logic [2:0] c;
      logic [15:0] d;
      int bad;
      load_ir(3'b010, c);
      check("R1 user1 loaded before reset", usr1_sel, 1);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 5; i++) step(1, 0);
      @(posedge tck); #2;
      check("R1 five tms-high edges clear select", {usr1_sel, usr2_sel}, 0);
      step(0, 0);
      usr1_tdo = 1; usr2_tdo = 1; bsr_tdo = 1;
      scan_dr(4, 16'h0006, d, bad);
      check("R1 bypass after tms reset", d, bypass_exp(4, 16'h0006));
   endtask

   initial begin
      repeat (20000) @(posedge tck);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      test_reset();
      test_ir_capture();
      test_bypass();
      test_user();
      test_boundary();
      test_unused();
      test_idle();
      test_tms_reset();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule